// File: doc/BRIEF.md
# Queue Doorbell Decoder and Tracker

This block sits behind a register-write port and receives 64-bit doorbell words that software writes to announce work. Each accepted word either moves the submission-queue tail or the completion-queue head of one queue in a small array. For every queue the block also keeps a consumed pointer. Downstream hardware advances that pointer with a one-cycle strobe. From the tail and the consumed pointer the block reports how many entries are still waiting.

A doorbell word is decoded by fixed bit position:
- bits 11:0 hold the queue number;
- bits 15:12 hold the command;
- bits 23:16 hold a signature byte;
- bits 47:32 hold the ring index;
- bits 63:48 hold a priority field, which this block ignores.

Words that fail validation leave every pointer as it was. A failed word sets a sticky error flag and bumps a reject counter. A separate counter tallies accepted words. Every update is registered and becomes visible on the outputs one clock after the write.

Top module: `dbell_tracker`

## Requirements
- R1: On synchronous reset, every tail, head and consumed pointer, every pending count, the error flag and both counters read 0.
- R2: A write whose signature (bits 23:16) is 0x5A and whose command (bits 15:12) is 0 loads the index (bits 47:32) into the tail of the queue named by bits 11:0, one clock after the write. The pointers of other queues do not change.
- R3: A write with a 0x5A signature and command 1 loads the index into that queue's completion head, one clock after the write.
- R4: Bits 63:48 of a doorbell have no effect on any output.
- R5: A write is rejected if any of these holds: the signature is not 0x5A, the queue number is NUM_Q or above, the index is DEPTH or above, or the command is above 1. A rejected write changes no pointer, sets the error flag and adds one to the reject counter.
- R6: Once set, the error flag stays set until reset.
- R7: The pending count of each queue equals (tail − consumed) mod DEPTH.
- R8: A consume strobe advances that queue's consumed pointer by one, wrapping from DEPTH−1 to 0, only while its pending count is nonzero. When the pending count is zero, the strobe has no effect.
- R9: The accepted counter adds one per valid doorbell and holds at all-ones.
- R10: The reject counter holds at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| db_valid | input | 1 | Doorbell write strobe |
| db_word | input | 64 | Doorbell word |
| consume | input | NUM_Q | Per-queue consume strobe |
| sq_tail_o | output | NUM_Q*IDX_W | Submission tails, queue q at [q*IDX_W +: IDX_W] |
| cq_head_o | output | NUM_Q*IDX_W | Completion heads, same packing |
| pending_o | output | NUM_Q*IDX_W | Pending counts, same packing |
| err_flag | output | 1 | Sticky rejection flag |
| rej_count | output | CNT_W | Saturating reject counter |
| acc_count | output | CNT_W | Saturating accepted counter |

## Verification
The bench builds the block with NUM_Q=3, DEPTH=12 and CNT_W=4. Three queues leave queue number 3 as a reachable out-of-range value. A depth that is not a power of two makes the modulo and wrap arithmetic differ from plain bit truncation, and ring indices 12 and 13 test the out-of-range index check. A 4-bit counter width makes both counters reach saturation within a few hundred cycles of mixed valid and malformed traffic.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int QN_LSB  = 0;
  localparam int CMD_LSB = 12;
  localparam int SIG_LSB = 16;
  localparam int IDX_LSB = 32;
  localparam logic [7:0] SIG_OK = 8'h5A;

  typedef enum logic [1:0] {DB_NONE, DB_SQ, DB_CQ, DB_BAD} db_kind_e;

  typedef struct packed {
    db_kind_e    kind;
    logic [11:0] qn;
    logic [15:0] idx;
  } db_dec_t;

  // distance from b forward to a on a ring of the given depth
  function automatic logic [31:0] ring_dist(logic [31:0] a, logic [31:0] b,
                                            logic [31:0] depth);
    if (a >= b) return a - b;
    return a + depth - b;
  endfunction

  // next slot on a ring, wrapping at depth-1
  function automatic logic [31:0] ring_step(logic [31:0] p, logic [31:0] depth);
    if (p == depth - 1) return 32'd0;
    return p + 32'd1;
  endfunction
endpackage

// File: rtl/dbt_decode.sv
module dbt_decode import dbt_pkg::*; #(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 16
) (
  input  logic        valid,
  input  logic [63:0] word,
  output db_dec_t     dec
);
  logic [11:0] qn;
  logic [3:0]  cmd;
  logic [7:0]  sig;
  logic [15:0] idx;
  logic        sig_good, qn_good, idx_good, cmd_good;
  logic        unused_bits;

  assign qn  = word[QN_LSB  +: 12];
  assign cmd = word[CMD_LSB +: 4];
  assign sig = word[SIG_LSB +: 8];
  assign idx = word[IDX_LSB +: 16];
  assign unused_bits = ^{word[63:48], word[31:24]};

  assign sig_good = (sig == SIG_OK);
  assign qn_good  = ({20'd0, qn} < 32'(NUM_Q));
  assign idx_good = ({16'd0, idx} < 32'(DEPTH));
  assign cmd_good = (cmd <= 4'd1);

  always_comb begin
    dec.qn  = qn;
    dec.idx = idx;
    if (!valid)
      dec.kind = DB_NONE;
    else if (!(sig_good && qn_good && idx_good && cmd_good))
      dec.kind = DB_BAD;
    else if (cmd == 4'd0)
      dec.kind = DB_SQ;
    else
      dec.kind = DB_CQ;
  end
endmodule

// File: rtl/dbt_queue.sv
module dbt_queue import dbt_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sq_wr,
  input  logic             cq_wr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             consume,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] pending
);
  logic [IDX_W-1:0] cons;
  logic [31:0]      dist_w, next_w;
  logic             advance;

  assign dist_w  = ring_dist(32'(tail), 32'(cons), 32'(DEPTH));
  assign next_w  = ring_step(32'(cons), 32'(DEPTH));
  assign pending = dist_w[IDX_W-1:0];
  assign advance = consume && (pending != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tail <= '0;
      head <= '0;
      cons <= '0;
    end else begin
      if (sq_wr)   tail <= wr_idx;
      if (cq_wr)   head <= wr_idx;
      if (advance) cons <= next_w[IDX_W-1:0];
    end
  end

  // R2
  tail_load_chk: assert property (@(posedge clk) disable iff (rst)
    sq_wr |=> tail == $past(wr_idx));

  // R3
  head_load_chk: assert property (@(posedge clk) disable iff (rst)
    cq_wr |=> head == $past(wr_idx));

  // R8
  consume_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (consume && pending == '0 && !sq_wr) |=> pending == '0);

  // R7
  pending_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(pending) < 32'(DEPTH));
endmodule

// File: rtl/dbt_satcnt.sv
module dbt_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic at_max;
  assign at_max = (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (inc && !at_max) cnt <= cnt + 1'b1;
  end

  // R9 R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    at_max |=> cnt == {W{1'b1}});

  // R9
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !at_max) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/dbell_tracker.sv
module dbell_tracker import dbt_pkg::*; #(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   db_valid,
  input  logic [63:0]            db_word,
  input  logic [NUM_Q-1:0]       consume,
  output logic [NUM_Q*IDX_W-1:0] sq_tail_o,
  output logic [NUM_Q*IDX_W-1:0] cq_head_o,
  output logic [NUM_Q*IDX_W-1:0] pending_o,
  output logic                   err_flag,
  output logic [CNT_W-1:0]       rej_count,
  output logic [CNT_W-1:0]       acc_count
);
  db_dec_t          dec;
  logic [NUM_Q-1:0] sq_wr, cq_wr;
  logic             accepted, rejected;
  logic [IDX_W-1:0] wr_idx;
  logic             unused_idx;

  dbt_decode #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) u_dec (
    .valid(db_valid), .word(db_word), .dec(dec));

  assign accepted   = (dec.kind == DB_SQ) || (dec.kind == DB_CQ);
  assign rejected   = (dec.kind == DB_BAD);
  assign wr_idx     = dec.idx[IDX_W-1:0];
  assign unused_idx = ^dec.idx;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign sq_wr[q] = (dec.kind == DB_SQ) && (dec.qn == 12'(q));
    assign cq_wr[q] = (dec.kind == DB_CQ) && (dec.qn == 12'(q));

    dbt_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_q (
      .clk(clk), .rst(rst),
      .sq_wr(sq_wr[q]), .cq_wr(cq_wr[q]), .wr_idx(wr_idx),
      .consume(consume[q]),
      .tail(sq_tail_o[q*IDX_W +: IDX_W]),
      .head(cq_head_o[q*IDX_W +: IDX_W]),
      .pending(pending_o[q*IDX_W +: IDX_W]));
  end

  always_ff @(posedge clk) begin
    if (rst)           err_flag <= 1'b0;
    else if (rejected) err_flag <= 1'b1;
  end

  dbt_satcnt #(.W(CNT_W)) u_acc (.clk(clk), .rst(rst), .inc(accepted), .cnt(acc_count));
  dbt_satcnt #(.W(CNT_W)) u_rej (.clk(clk), .rst(rst), .inc(rejected), .cnt(rej_count));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  // R5
  reject_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    rejected |-> (sq_wr == '0) && (cq_wr == '0));

  // R5
  reject_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rejected |=> err_flag);

  // R2 R3
  onehot_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sq_wr, cq_wr}));
endmodule

// File: tb/sim_dbell_tracker.sv
module sim_dbell_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 3;
  localparam int DP = 12;
  localparam int CW = 4;
  localparam int IW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              db_valid = 1'b0;
  logic [63:0]       db_word = '0;
  logic [NQ-1:0]     consume = '0;
  logic [NQ*IW-1:0]  sq_tail_o, cq_head_o, pending_o;
  logic              err_flag;
  logic [CW-1:0]     rej_count, acc_count;

  int vec = 0;
  int miss = 0;
  bit done = 0;

  int m_tail[NQ];
  int m_head[NQ];
  int m_cons[NQ];
  int m_err, m_rej, m_acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbell_tracker #(.NUM_Q(NQ), .DEPTH(DP), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .db_valid(db_valid), .db_word(db_word),
    .consume(consume), .sq_tail_o(sq_tail_o), .cq_head_o(cq_head_o),
    .pending_o(pending_o), .err_flag(err_flag), .rej_count(rej_count),
    .acc_count(acc_count));

  function automatic logic [63:0] mk(int q, int cmd, int sig, int idx, int pri);
    return {pri[15:0], idx[15:0], 8'h00, sig[7:0], cmd[3:0], q[11:0]};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    vec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int q = 0; q < NQ; q++) begin
      int pend;
      pend = (m_tail[q] - m_cons[q] + DP) % DP;
      chk("R2", $sformatf("tail q%0d", q), int'(sq_tail_o[q*IW +: IW]), m_tail[q]);
      chk("R3", $sformatf("head q%0d", q), int'(cq_head_o[q*IW +: IW]), m_head[q]);
      chk("R7", $sformatf("pending q%0d", q), int'(pending_o[q*IW +: IW]), pend);
    end
    chk("R6", "err_flag", int'(err_flag), m_err);
    chk("R5", "rej_count", int'(rej_count), m_rej);
    chk("R9", "acc_count", int'(acc_count), m_acc);
  endtask

  task automatic model_update(logic v, logic [63:0] w, logic [NQ-1:0] c);
    int q, cmd, sig, idx;
    for (int i = 0; i < NQ; i++)
      if (c[i] && ((m_tail[i] - m_cons[i] + DP) % DP) != 0)
        m_cons[i] = (m_cons[i] + 1) % DP;
    if (v) begin
      q = int'(w[11:0]); cmd = int'(w[15:12]); sig = int'(w[23:16]); idx = int'(w[47:32]);
      if (sig != 8'h5A || q >= NQ || idx >= DP || cmd > 1) begin
        m_err = 1;
        if (m_rej < CMAX) m_rej++;
      end else begin
        if (m_acc < CMAX) m_acc++;
        if (cmd == 0) m_tail[q] = idx;
        else          m_head[q] = idx;
      end
    end
  endtask

  task automatic step(logic v, logic [63:0] w, logic [NQ-1:0] c);
    db_valid = v; db_word = w; consume = c;
    @(posedge clk);
    model_update(v, w, c);
    @(negedge clk);
    db_valid = 1'b0; consume = '0;
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog expired before the run finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin m_tail[q] = 0; m_head[q] = 0; m_cons[q] = 0; end
    m_err = 0; m_rej = 0; m_acc = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "tails", int'(sq_tail_o), 0);
    chk("R1", "heads", int'(cq_head_o), 0);
    chk("R1", "pending", int'(pending_o), 0);
    chk("R1", "err", int'(err_flag), 0);
    chk("R1", "counts", int'({rej_count, acc_count}), 0);

    // R2 submission doorbell, then drain with consume (R8)
    step(1, mk(0, 0, 8'h5A, 5, 0), '0);
    chk("R2", "q0 tail after write", int'(sq_tail_o[0 +: IW]), 5);
    for (int i = 0; i < 5; i++) step(0, '0, 3'b001);
    chk("R8", "q0 drained", int'(pending_o[0 +: IW]), 0);
    step(0, '0, 3'b001);
    chk("R8", "consume at zero", int'(pending_o[0 +: IW]), 0);
    // R3 completion doorbell
    step(1, mk(1, 1, 8'h5A, 11, 0), '0);
    chk("R3", "q1 head", int'(cq_head_o[IW +: IW]), 11);
    // R4 priority bits ignored
    step(1, mk(2, 0, 8'h5A, 3, 16'hFFFF), '0);
    chk("R4", "q2 tail with priority set", int'(sq_tail_o[2*IW +: IW]), 3);
    // R5 each reject kind
    step(1, mk(0, 0, 8'h5B, 1, 0), '0);
    chk("R5", "bad signature flag", int'(err_flag), 1);
    step(1, mk(3, 0, 8'h5A, 1, 0), '0);
    step(1, mk(1, 0, 8'h5A, 12, 0), '0);
    step(1, mk(1, 2, 8'h5A, 1, 0), '0);
    chk("R5", "reject count", int'(rej_count), 4);
    chk("R5", "q1 tail untouched", int'(sq_tail_o[IW +: IW]), 0);
    // R8 wrap of consumed pointer
    step(1, mk(1, 0, 8'h5A, 11, 0), '0);
    for (int i = 0; i < 11; i++) step(0, '0, 3'b010);
    step(1, mk(1, 0, 8'h5A, 2, 0), '0);
    chk("R8", "pending across wrap", int'(pending_o[IW +: IW]), 3);
    for (int i = 0; i < 3; i++) step(0, '0, 3'b010);
    chk("R8", "drained after wrap", int'(pending_o[IW +: IW]), 0);

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      int sig, q, cmd, idx;
      sig = ($urandom % 8 == 0) ? int'($urandom % 256) : 8'h5A;
      q   = int'($urandom % 4);
      cmd = ($urandom % 6 == 0) ? int'(2 + $urandom % 14) : int'($urandom % 2);
      idx = int'($urandom % 14);
      step(($urandom % 10) < 7, mk(q, cmd, sig, idx, int'($urandom)), NQ'($urandom));
    end
    chk("R9", "accepted saturated", int'(acc_count), CMAX);
    for (int i = 0; i < 20; i++) step(1, mk(0, 0, 8'h00, 0, 0), '0);
    chk("R10", "reject saturated", int'(rej_count), CMAX);
    chk("R6", "flag still set", int'(err_flag), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule